// File: doc/BRIEF.md
# Stochastic Bitstream Shuffler

This block reorders a serial stochastic bitstream so that its bits lose their position-to-position correlation with other streams built from the same source. Bits arrive one per cycle, and the reordered stream leaves one bit per cycle. The count of ones is preserved exactly, so the value the stream carries does not change.

Storage is a five-cell line: a centre read cell with a two-cell half on each side. Every accepted input bit is written into both outer cells at once. On each step only one half moves one place toward the centre. The bit it pushes into the centre cell becomes the next output. A coin bit supplied from outside chooses which half moves.

Two fixed steps open each stream and fill both inner cells. Then come N−2 coin-driven steps. Two fixed steps at the end empty the line. The first shuffled bit appears while the input is still arriving, so output starts before the whole stream has been received.

Top module: `sbit_shuffler`

## Requirements
- R1: After reset, `out_valid` and `done` are low and `out_bit` is 0.
- R2: After `start` from idle, the first accepted input bit is placed in the right inner cell regardless of `rnd_bit`. It produces no output.
- R3: The second accepted input bit is placed in the left inner cell regardless of `rnd_bit`. It produces no output.
- R4: From the third accepted input bit onward, `rnd_bit` = 0 emits the bit held in the left inner cell, and the new bit takes that cell's place. `rnd_bit` = 1 does the same with the right half. The other half is left unchanged.
- R5: The output for a step is presented on `out_bit` with `out_valid` high in the cycle after the clock edge that accepts the input bit.
- R6: Each stream raises `out_valid` exactly STREAM_LEN times.
- R7: After the last input bit, two drain steps follow automatically with no input and without regard to `rnd_bit`. The first emits the right inner cell and the second emits the left inner cell. `in_valid` must be low during them.
- R8: `done` is high for exactly one cycle, in the cycle after the last `out_valid`.
- R9: `start` is ignored while a stream is in progress, and `in_valid` is ignored while idle.
- R10: A cycle with `in_valid` low during the input phases advances nothing and emits nothing.
- R11: The number of ones in the output stream equals the number of ones in the input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new stream when idle |
| in_valid | input | 1 | `in_bit` is offered this cycle |
| in_bit | input | 1 | Serial input stream bit |
| rnd_bit | input | 1 | Coin bit: 0 advances the left half, 1 the right half |
| out_valid | output | 1 | `out_bit` carries a shuffled bit |
| out_bit | output | 1 | Serial shuffled stream bit |
| done | output | 1 | One-cycle pulse after the final output of a stream |

## Verification
The checker assumes that `in_valid` stays low during the two drain steps. It also assumes that `start` and `in_valid` are ordinary synchronous levels, so a cycle either accepts a bit or does not. The stimulus drops `in_valid` as soon as the last bit of a stream has been offered, and it keeps `in_valid` low until the next `start`. The only exception is a deliberate burst of input while the block is idle, which must be ignored. Inside this envelope the stimulus varies `rnd_bit` freely, opposes the forced direction during the priming and drain steps, inserts stall cycles, and pulses `start` in the middle of a stream.

// File: rtl/shuf_pkg.sv
`timescale 1ns/1ps
// Shared types for the stochastic bitstream shuffler.
// Assumes nothing beyond standard SystemVerilog enums.
package shuf_pkg;

    // Sequencer phases of one stream.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRIME   = 3'd1,
        ST_RUN     = 3'd2,
        ST_DRAIN_R = 3'd3,
        ST_DRAIN_L = 3'd4,
        ST_FIN     = 3'd5
    } shuf_state_e;

    // Which half of the line advances; the value doubles as the half index.
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shuf_dir_e;

    localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/shuf_ctrl.sv
`timescale 1ns/1ps
// Step sequencer: walks one stream through priming, coin-driven and draining
// steps, and tells the storage line when to load, when to advance, and whether
// the direction is forced.
// Assumes STREAM_LEN >= 2 and that in_valid is low during the drain steps.
module shuf_ctrl
    import shuf_pkg::*;
#(
    parameter int unsigned STREAM_LEN = 8,
    localparam int unsigned CNT_W = (STREAM_LEN > 2) ? $clog2(STREAM_LEN) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        in_valid,
    output shuf_state_e state_o,
    output logic        load_o,
    output logic        step_o,
    output logic        set_en_o,
    output shuf_dir_e   set_dir_o,
    output logic        emit_o,
    output logic        fin_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(STREAM_LEN - 1);

    shuf_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and step-control decode for the current phase.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        load_o    = 1'b0;
        step_o    = 1'b0;
        set_en_o  = 1'b0;
        set_dir_o = DIR_LEFT;
        emit_o    = 1'b0;
        fin_o     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PRIME;
                    cnt_d   = '0;
                end
            end
            ST_PRIME: begin
                if (in_valid) begin
                    load_o    = 1'b1;
                    step_o    = 1'b1;
                    set_en_o  = 1'b1;
                    set_dir_o = (cnt_q == '0) ? DIR_RIGHT : DIR_LEFT;
                    cnt_d     = cnt_q + 1'b1;
                    if (cnt_q != '0) begin
                        state_d = (STREAM_LEN == 2) ? ST_DRAIN_R : ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (in_valid) begin
                    load_o = 1'b1;
                    step_o = 1'b1;
                    emit_o = 1'b1;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX) begin
                        state_d = ST_DRAIN_R;
                    end
                end
            end
            ST_DRAIN_R: begin
                step_o    = 1'b1;
                set_en_o  = 1'b1;
                set_dir_o = DIR_RIGHT;
                emit_o    = 1'b1;
                state_d   = ST_DRAIN_L;
            end
            ST_DRAIN_L: begin
                step_o    = 1'b1;
                set_en_o  = 1'b1;
                set_dir_o = DIR_LEFT;
                emit_o    = 1'b1;
                state_d   = ST_FIN;
            end
            ST_FIN: begin
                fin_o   = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase and accepted-bit counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/shuf_dir_sel.sv
`timescale 1ns/1ps
// Direction select: a forced direction wins over the coin bit whenever the
// sequencer asserts its set-enable.
// Assumes rnd_bit is a settled synchronous input.
module shuf_dir_sel
    import shuf_pkg::*;
(
    input  logic      set_en,
    input  shuf_dir_e set_dir,
    input  logic      rnd_bit,
    output shuf_dir_e dir_o
);

    // Choose the forced direction or the coin.
    always_comb begin
        dir_o = set_en ? set_dir : shuf_dir_e'(rnd_bit);
    end

endmodule

// File: rtl/shuf_half.sv
`timescale 1ns/1ps
// One half of the storage line: an outer cell that receives input bits and an
// inner cell next to the centre. On advance, the (possibly freshly loaded)
// outer value moves into the inner cell.
// Assumes load is asserted only together with a step of the whole line.
module shuf_half (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_bit,
    input  logic adv,
    output logic inner_o
);

    logic outer_q, inner_q, outer_n;

    // Outer value as seen after this step's write.
    always_comb begin
        outer_n = load ? load_bit : outer_q;
    end

    // Outer and inner cell update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outer_q <= 1'b0;
            inner_q <= 1'b0;
        end else begin
            outer_q <= outer_n;
            if (adv) begin
                inner_q <= outer_n;
            end
        end
    end

    assign inner_o = inner_q;

endmodule

// File: rtl/shuf_line.sv
`timescale 1ns/1ps
// Five-cell storage line: two halves around a centre cell. A step advances
// only the half named by dir; its old inner bit enters the centre.
// Assumes dir is valid whenever step is high.
module shuf_line
    import shuf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  in_bit,
    input  logic                  step,
    input  shuf_dir_e             dir,
    output logic                  centre_o,
    output logic [NUM_HALVES-1:0] inner_o
);

    logic [NUM_HALVES-1:0] inner;
    logic                  centre_q;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        shuf_half u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_bit (in_bit),
            .adv      (step && (dir == shuf_dir_e'(h))),
            .inner_o  (inner[h])
        );
    end

    // Centre cell takes the old inner bit of the advancing half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            centre_q <= 1'b0;
        end else if (step) begin
            centre_q <= inner[dir];
        end
    end

    assign centre_o = centre_q;
    assign inner_o  = inner;

endmodule

// File: rtl/sbit_shuffler.sv
`timescale 1ns/1ps
// Stochastic bitstream shuffler top: sequencer, direction select and storage
// line, with registered output valid and done flags.
// Assumes STREAM_LEN >= 2, one input bit per accepted cycle, and in_valid low
// between the last input bit and the next start.
module sbit_shuffler
    import shuf_pkg::*;
#(
    parameter int unsigned STREAM_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic in_bit,
    input  logic rnd_bit,
    output logic out_valid,
    output logic out_bit,
    output logic done
);

    shuf_state_e           st;
    logic                  ld, stp, set_en, emit, fin;
    shuf_dir_e             set_dir, dir;
    logic [NUM_HALVES-1:0] inner;
    logic                  out_valid_q, done_q;

    shuf_ctrl #(.STREAM_LEN(STREAM_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .state_o   (st),
        .load_o    (ld),
        .step_o    (stp),
        .set_en_o  (set_en),
        .set_dir_o (set_dir),
        .emit_o    (emit),
        .fin_o     (fin)
    );

    shuf_dir_sel u_dir (
        .set_en  (set_en),
        .set_dir (set_dir),
        .rnd_bit (rnd_bit),
        .dir_o   (dir)
    );

    shuf_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .in_bit   (in_bit),
        .step     (stp),
        .dir      (dir),
        .centre_o (out_bit),
        .inner_o  (inner)
    );

    // Registered output-valid and end-of-stream flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            out_valid_q <= emit;
            done_q      <= fin;
        end
    end

    assign out_valid = out_valid_q;
    assign done      = done_q;

endmodule

// File: rtl/shuf_checks.sv
`timescale 1ns/1ps
// Protocol and ordering checker for sbit_shuffler, attached by bind.
// Assumes in_valid is low in the drain phases (checked as an input rule).
module shuf_checks
    import shuf_pkg::*;
#(
    parameter int unsigned STREAM_LEN = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        rnd_bit,
    input logic        out_valid,
    input logic        out_bit,
    input logic        done,
    input shuf_state_e st,
    input logic [1:0]  inner
);

    int unsigned vcnt;

    // Count valid outputs since the previous done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     vcnt <= 0;
        else if (done)  vcnt <= 0;
        else if (out_valid) vcnt <= vcnt + 1;
    end

    // R2, R3: priming steps emit nothing.
    a_r2_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRIME) |=> !out_valid);

    // R4: a left coin in the run phase emits the old left inner bit.
    a_r4_left_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && in_valid && !rnd_bit) |=> (out_valid && out_bit == $past(inner[0])));

    // R4: a right coin in the run phase emits the old right inner bit.
    a_r4_right_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && in_valid && rnd_bit) |=> (out_valid && out_bit == $past(inner[1])));

    // R7: right drain is followed by left drain, which emits.
    a_r7_drain_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN_R) |=> (st == ST_DRAIN_L && out_valid));

    // R7: input rule, no input offered while draining.
    a_r7_no_input_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN_R || st == ST_DRAIN_L) |-> !in_valid);

    // R8: done lasts one cycle and follows an output.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_out: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && !out_valid));

    // R6: exactly STREAM_LEN outputs precede done.
    a_r6_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt == STREAM_LEN));

    // R10: no output while the run phase is stalled.
    a_r10_stall_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !in_valid) |=> !out_valid);

    // R9: priming is entered only from idle.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_PRIME) |=> (st != ST_PRIME));

endmodule

bind sbit_shuffler shuf_checks #(.STREAM_LEN(STREAM_LEN)) u_shuf_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rnd_bit   (rnd_bit),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .done      (done),
    .st        (st),
    .inner     (inner)
);

// File: tb/test_sbit_shuffler.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural two-slot model predicts every cycle.
module test_sbit_shuffler;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic rnd_bit = 1'b0;
    logic out_valid, out_bit, done;

    int checks = 0;
    int errors = 0;
    int vcount, ones_out;
    int m_left, m_right;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sbit_shuffler #(.STREAM_LEN(N)) i_sbit_shuffler (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_bit(in_bit), .rnd_bit(rnd_bit), .out_valid(out_valid),
        .out_bit(out_bit), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge, then compare outputs against the model's prediction.
    task automatic step_check(input int ev, input int eb, input int ed, input string req);
        @(posedge clk);
        @(negedge clk);
        if (out_valid) begin
            vcount++;
            ones_out += int'(out_bit);
        end
        chk({req, " out_valid"}, int'(out_valid), ev);
        if (ev != 0) chk({req, " out_bit"}, int'(out_bit), eb);
        chk({req, " done"}, int'(done), ed);
    endtask

    task automatic run_stream(input int mode, input bit gaps, input bit glitch, input bit idle_noise);
        int ones_in = 0;
        vcount = 0;
        ones_out = 0;
        if (idle_noise) begin
            in_valid = 1'b1;
            in_bit = 1'b1;
            repeat (3) step_check(0, 0, 0, "R9 idle input ignored");
            in_valid = 1'b0;
            vcount = 0;
            ones_out = 0;
        end
        start = 1'b1;
        step_check(0, 0, 0, "R9 start accepted");
        start = 1'b0;
        for (int i = 0; i < N; i++) begin
            int b, r, e;
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                rnd_bit = 1'($urandom);
                step_check(0, 0, 0, "R10 stall");
            end
            b = int'($urandom % 2);
            case (mode)
                0: r = 0;
                1: r = 1;
                2: r = i % 2;
                default: r = int'($urandom % 2);
            endcase
            ones_in += b;
            in_valid = 1'b1;
            in_bit = 1'(b);
            start = glitch && (i == 4);
            if (i == 0) begin
                rnd_bit = 1'b0;
                m_right = b;
                step_check(0, 0, 0, "R2 prime right");
            end else if (i == 1) begin
                rnd_bit = 1'b1;
                m_left = b;
                step_check(0, 0, 0, "R3 prime left");
            end else begin
                rnd_bit = 1'(r);
                if (r != 0) begin e = m_right; m_right = b; end
                else begin e = m_left; m_left = b; end
                step_check(1, e, 0, "R4 R5 coin step");
            end
        end
        in_valid = 1'b0;
        start = 1'b0;
        rnd_bit = 1'b0;
        step_check(1, m_right, 0, "R7 drain right");
        rnd_bit = 1'b1;
        step_check(1, m_left, 0, "R7 drain left");
        step_check(0, 0, 1, "R8 done pulse");
        step_check(0, 0, 0, "R8 done single");
        chk("R6 output count", vcount, N);
        chk("R11 ones preserved", ones_out, ones_in);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset out_bit", int'(out_bit), 0);
        rst_n = 1'b1;
        step_check(0, 0, 0, "R1 idle after reset");
        run_stream(0, 1'b0, 1'b0, 1'b1);
        run_stream(1, 1'b0, 1'b0, 1'b0);
        run_stream(2, 1'b1, 1'b0, 1'b0);
        run_stream(3, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) run_stream(3, k[0], k[1], k[2]);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule